// File: doc/BRIEF.md
# Prioritized Hardware Sprite Pixel Mixer

This block sits in a video pipeline between the beam position counters and the palette lookup. For every beam position it picks one winner among three kinds of source: the border, up to sixteen hardware sprites, and the background (main screen) pixel stream. A register bus loads each sprite's own state:
- a 16x16 image of 4-bit palette indices,
- a signed X and Y position,
- a magnification byte with an independent zoom code for each axis.

Each beam coordinate is compared against every sprite in parallel. A lane covers a window whose size is scaled by its zoom, divides its offset inside that window by the zoom factor to find the image pixel, and reports whether that pixel is opaque. A fixed priority picks the lowest-numbered opaque sprite. The border overrides everything, and the screen pixel fills whatever remains.

The result is one registered palette index plus a two-bit source tag. The palette uses the tag to choose between its screen bank and its sprite bank. Sprite placement does not depend on any smooth-scroll offset applied to the screen data.

Top module: `sprmix_top`

## Requirements
- R1: While reset is asserted, the outputs are tag 0 (screen) and index 0. Every magnification register clears to 0, so no sprite appears until one is programmed.
- R2: When `border_in` is high, the next output is tag 2 (border) with index 0, whatever the sprites and the screen show.
- R3: Where several sprites have opaque pixels at one position, the sprite with the lowest number wins. Its index is output with tag 1 (sprite).
- R4: A sprite pixel whose low four bits are 0 is transparent: the next opaque higher-numbered sprite shows, or the screen if there is none.
- R5: The upper four bits of an image byte are ignored, so a byte 0xF0 is transparent.
- R6: In the magnification byte, bits 3..2 are the X code and bits 1..0 the Y code. Code 00 on either axis hides the sprite, and bits 7..4 are ignored.
- R7: Zoom codes 01, 10 and 11 scale by 1, 2 and 4. A sprite spans 16 times the factor on that axis, and the pixel used is the beam offset divided by the factor (row*16+column).
- R8: Sprite positions are 16-bit two's complement, so a sprite may start left of or above coordinate 0. Only its on-screen part shows.
- R9: The output reflects the inputs sampled at the previous rising clock edge. Tag 3 never occurs.
- R10: Where no border and no opaque sprite pixel applies, the output is tag 0 with the screen index that was presented.
- R11: Bus writes take effect at the clock edge, and a pixel computed in that same cycle still uses the old contents.
  - Address bit 12 = 0 selects an image byte: bits 11..8 are the sprite and bits 7..0 the pixel (row*16+column).
  - Address bit 12 = 1 selects a control byte: bits 7..4 are the sprite and bits 2..0 the field (0 = X low, 1 = X high, 2 = Y low, 3 = Y high, 4 = magnification).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register bus write strobe |
| wr_addr | input | 13 | Register bus byte address |
| wr_data | input | 8 | Register bus write data |
| beam_x | input | 16 | Horizontal beam coordinate, two's complement |
| beam_y | input | 16 | Vertical beam coordinate, two's complement |
| border_in | input | 1 | Beam is in the border area |
| screen_idx | input | 4 | Palette index of the main screen pixel |
| pix_idx | output | 4 | Mixed palette index |
| pix_src | output | 2 | Source tag: 0 screen, 1 sprite, 2 border |

## Verification
Two functions can land in one clock cycle: a bus write that moves a sprite, and the mixing of a pixel that this same sprite covers. The bench provokes this by rewriting sprite 0's X low byte at the start of each scan row while the beam passes over that sprite. Its reference model computes the pixel from the state before the write and applies the write afterwards. The outputs must match that order on every clock, and the shifted column must appear from the next cycle on.

// File: rtl/sprmix_pkg.sv
package sprmix_pkg;

   typedef enum logic [1:0] {
      SRC_SCREEN = 2'd0,
      SRC_SPRITE = 2'd1,
      SRC_BORDER = 2'd2
   } src_e;

   localparam logic [2:0] FLD_X_LO = 3'd0;
   localparam logic [2:0] FLD_X_HI = 3'd1;
   localparam logic [2:0] FLD_Y_LO = 3'd2;
   localparam logic [2:0] FLD_Y_HI = 3'd3;
   localparam logic [2:0] FLD_MAG  = 3'd4;

   // zoom code to shift amount: 01 -> x1, 10 -> x2, 11 -> x4
   function automatic logic [1:0] zoom_shift(input logic [1:0] code);
      case (code)
         2'b10:   return 2'd1;
         2'b11:   return 2'd2;
         default: return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/sprmix_lane.sv
module sprmix_lane
   import sprmix_pkg::*;
#(
   parameter int SPR_ID  = 0,
   parameter int NUM_SPR = 16,
   parameter int IMG_DIM = 16,
   parameter int COORD_W = 16,
   parameter int IDX_W   = 4,
   parameter int ADDR_W  = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [7:0]         wr_data,
   input  logic [COORD_W-1:0] beam_x,
   input  logic [COORD_W-1:0] beam_y,
   output logic               opaque,
   output logic [IDX_W-1:0]   pix
);
   localparam int SEL_W = (NUM_SPR > 1) ? $clog2(NUM_SPR) : 1;
   localparam int IMG_W = $clog2(IMG_DIM);
   localparam int PIX_W = 2 * IMG_W;
   localparam int DEPTH = IMG_DIM * IMG_DIM;
   localparam logic [SEL_W-1:0]   MY_ID = SEL_W'(SPR_ID);
   localparam logic [COORD_W:0]   DIM_V = (COORD_W+1)'(IMG_DIM);

   logic [COORD_W-1:0] pos_x, pos_y;
   logic [3:0]         mag;
   logic [IDX_W-1:0]   img [DEPTH];

   logic img_sel, ctl_sel;
   assign img_sel = wr_en && !wr_addr[ADDR_W-1] && (wr_addr[PIX_W +: SEL_W] == MY_ID);
   assign ctl_sel = wr_en &&  wr_addr[ADDR_W-1] && (wr_addr[4 +: SEL_W] == MY_ID);

   always_ff @(posedge clk) begin
      if (img_sel) img[wr_addr[PIX_W-1:0]] <= wr_data[IDX_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (ctl_sel) begin
         case (wr_addr[2:0])
            FLD_X_LO: pos_x[7:0]         <= wr_data;
            FLD_X_HI: pos_x[COORD_W-1:8] <= wr_data[COORD_W-9:0];
            FLD_Y_LO: pos_y[7:0]         <= wr_data;
            FLD_Y_HI: pos_y[COORD_W-1:8] <= wr_data[COORD_W-9:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               mag <= '0;
      else if (ctl_sel && wr_addr[2:0] == FLD_MAG) mag <= wr_data[3:0];
   end

   logic signed [COORD_W:0] dx, dy;
   logic [COORD_W:0]        dxu, dyu, ext_x, ext_y;
   logic [1:0]              shx, shy;
   logic                    in_x, in_y, shown;
   logic [IMG_W-1:0]        col, row;

   always_comb begin
      dx    = $signed({beam_x[COORD_W-1], beam_x}) - $signed({pos_x[COORD_W-1], pos_x});
      dy    = $signed({beam_y[COORD_W-1], beam_y}) - $signed({pos_y[COORD_W-1], pos_y});
      dxu   = dx;
      dyu   = dy;
      shx   = zoom_shift(mag[3:2]);
      shy   = zoom_shift(mag[1:0]);
      ext_x = DIM_V << shx;
      ext_y = DIM_V << shy;
      in_x  = !dx[COORD_W] && (dxu < ext_x);
      in_y  = !dy[COORD_W] && (dyu < ext_y);
      col   = IMG_W'(dxu >> shx);
      row   = IMG_W'(dyu >> shy);
      shown = (mag[3:2] != 2'b00) && (mag[1:0] != 2'b00) && in_x && in_y;
   end

   assign pix    = img[{row, col}];
   assign opaque = shown && (pix != '0);

endmodule

// File: rtl/sprmix_prio.sv
module sprmix_prio #(
   parameter int NUM_SPR = 16,
   parameter int IDX_W   = 4
) (
   input  logic [NUM_SPR-1:0]       opaque,
   input  logic [NUM_SPR*IDX_W-1:0] pix_flat,
   output logic                     any,
   output logic [IDX_W-1:0]         win_idx
);
   // scan from the weakest lane so the lowest-numbered opaque lane lands last
   always_comb begin
      any     = 1'b0;
      win_idx = '0;
      for (int i = NUM_SPR - 1; i >= 0; i--) begin
         if (opaque[i]) begin
            any     = 1'b1;
            win_idx = pix_flat[i*IDX_W +: IDX_W];
         end
      end
   end
endmodule

// File: rtl/sprmix_top.sv
module sprmix_top
   import sprmix_pkg::*;
#(
   parameter int NUM_SPR = 16,
   parameter int IMG_DIM = 16,
   parameter int COORD_W = 16,
   parameter int IDX_W   = 4,
   parameter int ADDR_W  = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [7:0]         wr_data,
   input  logic [COORD_W-1:0] beam_x,
   input  logic [COORD_W-1:0] beam_y,
   input  logic               border_in,
   input  logic [IDX_W-1:0]   screen_idx,
   output logic [IDX_W-1:0]   pix_idx,
   output logic [1:0]         pix_src
);
   localparam int SEL_W = (NUM_SPR > 1) ? $clog2(NUM_SPR) : 1;
   localparam int PIX_W = 2 * $clog2(IMG_DIM);

   if (IMG_DIM < 2 || (IMG_DIM & (IMG_DIM - 1)) != 0) begin : g_bad_dim
      $error("IMG_DIM must be a power of two");
   end
   if (COORD_W < 9 || COORD_W > 16) begin : g_bad_coord
      $error("COORD_W must be within 9..16");
   end
   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
      $error("IDX_W must be within 1..8");
   end
   if (ADDR_W - 1 < SEL_W + PIX_W || ADDR_W - 1 < SEL_W + 4) begin : g_bad_addr
      $error("ADDR_W too small for sprite count and image size");
   end

   logic [NUM_SPR-1:0]       lane_opq;
   logic [NUM_SPR*IDX_W-1:0] lane_pix;
   logic                     spr_any;
   logic [IDX_W-1:0]         spr_idx;

   for (genvar g = 0; g < NUM_SPR; g++) begin : g_lane
      sprmix_lane #(
         .SPR_ID (g),       .NUM_SPR(NUM_SPR), .IMG_DIM(IMG_DIM),
         .COORD_W(COORD_W), .IDX_W  (IDX_W),   .ADDR_W (ADDR_W)
      ) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (wr_en),
         .wr_addr(wr_addr),
         .wr_data(wr_data),
         .beam_x (beam_x),
         .beam_y (beam_y),
         .opaque (lane_opq[g]),
         .pix    (lane_pix[g*IDX_W +: IDX_W])
      );
   end

   sprmix_prio #(.NUM_SPR(NUM_SPR), .IDX_W(IDX_W)) u_prio (
      .opaque  (lane_opq),
      .pix_flat(lane_pix),
      .any     (spr_any),
      .win_idx (spr_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_src <= SRC_SCREEN;
         pix_idx <= '0;
      end else if (border_in) begin
         pix_src <= SRC_BORDER;
         pix_idx <= '0;
      end else if (spr_any) begin
         pix_src <= SRC_SPRITE;
         pix_idx <= spr_idx;
      end else begin
         pix_src <= SRC_SCREEN;
         pix_idx <= screen_idx;
      end
   end

endmodule

// File: rtl/sprmix_chk.sv
module sprmix_chk
   import sprmix_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             border_in,
   input logic [IDX_W-1:0] screen_idx,
   input logic [IDX_W-1:0] pix_idx,
   input logic [1:0]       pix_src
);
   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   assert_border_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      border_in |=> (pix_src == SRC_BORDER && pix_idx == '0));

   assert_border_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && pix_src == SRC_BORDER) |-> $past(border_in));

   assert_sprite_opaque_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_src == SRC_SPRITE) |-> (pix_idx != '0));

   assert_screen_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && pix_src == SRC_SCREEN) |-> (pix_idx == $past(screen_idx)));

   assert_tag_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pix_src != 2'd3);
endmodule

bind sprmix_top sprmix_chk #(.IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .border_in (border_in),
   .screen_idx(screen_idx),
   .pix_idx   (pix_idx),
   .pix_src   (pix_src)
);

// File: tb/tb_sprmix_top.sv
module tb_sprmix_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [12:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [15:0] beam_x = '0;
   logic [15:0] beam_y = '0;
   logic        border_in = 1'b0;
   logic [3:0]  screen_idx = '0;
   logic [3:0]  pix_idx;
   logic [1:0]  pix_src;

   always #5 clk = ~clk;

   sprmix_top dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .beam_x(beam_x), .beam_y(beam_y), .border_in(border_in), .screen_idx(screen_idx),
      .pix_idx(pix_idx), .pix_src(pix_src)
   );

   int checks = 0;
   int errors = 0;

   // behavioural reference state
   int m_img [16][256];
   int m_x [16];
   int m_y [16];
   int m_mag [16];

   int    exp_src, exp_idx;
   string exp_lbl;
   bit    have_exp = 0;

   function automatic int sgn16(input int v);
      return (v >= 32768) ? v - 65536 : v;
   endfunction

   task automatic model(input int bx, input int by, input int bd, input int scr,
                        output int esrc, output int eidx, output string why);
      esrc = 0; eidx = scr; why = "R10";
      for (int s = 15; s >= 0; s--) begin
         int zx, zy, fx, fy, dx, dy, p;
         zx = (m_mag[s] >> 2) & 3;
         zy = m_mag[s] & 3;
         if (zx == 0 || zy == 0) continue;
         fx = 1 << (zx - 1);
         fy = 1 << (zy - 1);
         dx = bx - sgn16(m_x[s]);
         dy = by - sgn16(m_y[s]);
         if (dx < 0 || dy < 0 || dx >= 16 * fx || dy >= 16 * fy) continue;
         p = m_img[s][(dy / fy) * 16 + (dx / fx)];
         if (p != 0) begin esrc = 1; eidx = p; why = "R3"; end
      end
      if (bd != 0) begin esrc = 2; eidx = 0; why = "R2"; end
   endtask

   task automatic model_write(input int wa, input int wd);
      int s, f;
      if (((wa >> 12) & 1) == 0) begin
         m_img[(wa >> 8) & 15][wa & 255] = wd & 15;
      end else begin
         s = (wa >> 4) & 15;
         f = wa & 7;
         case (f)
            0: m_x[s] = (m_x[s] & 16'hFF00) | (wd & 255);
            1: m_x[s] = (m_x[s] & 16'h00FF) | ((wd & 255) << 8);
            2: m_y[s] = (m_y[s] & 16'hFF00) | (wd & 255);
            3: m_y[s] = (m_y[s] & 16'h00FF) | ((wd & 255) << 8);
            4: m_mag[s] = wd & 15;
            default: ;
         endcase
      end
   endtask

   // one clock: check the result of the previous step, then present new inputs
   task automatic step(input int bx, input int by, input int bd, input int scr,
                       input bit we, input int wa, input int wd, input string lbl);
      string why;
      @(negedge clk);
      if (have_exp) begin
         checks++;
         if (pix_src !== 2'(exp_src) || pix_idx !== 4'(exp_idx)) begin
            errors++;
            $display("FAIL %s: src=%0d idx=%0d expected src=%0d idx=%0d", exp_lbl,
                     pix_src, pix_idx, exp_src, exp_idx);
         end
      end
      beam_x     = 16'(bx);
      beam_y     = 16'(by);
      border_in  = (bd != 0);
      screen_idx = 4'(scr);
      wr_en      = we;
      wr_addr    = 13'(wa);
      wr_data    = 8'(wd);
      model(bx, by, bd, scr, exp_src, exp_idx, why);
      if (we) model_write(wa, wd);
      exp_lbl  = {why, " R9 ", lbl};
      have_exp = 1;
   endtask

   task automatic wr_ctl(input int s, input int f, input int v);
      step(-100, -100, 0, 3, 1, 'h1000 | (s << 4) | f, v, "R11 control write");
   endtask

   task automatic set_pos(input int s, input int x, input int y);
      wr_ctl(s, 0, x & 255);
      wr_ctl(s, 1, (x >> 8) & 255);
      wr_ctl(s, 2, y & 255);
      wr_ctl(s, 3, (y >> 8) & 255);
   endtask

   task automatic scan(input int x0, input int x1, input int y0, input int y1,
                       input int bmode, input string lbl);
      for (int y = y0; y <= y1; y++) begin
         for (int x = x0; x <= x1; x++) begin
            int bd;
            bd = (bmode != 0 && ((x * 3 + y + 70) % 7) == 0) ? 1 : 0;
            step(x, y, bd, (x + 2 * y + 40) & 15, 0, 0, 0, lbl);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R9 watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int s = 0; s < 16; s++) begin
         m_x[s] = 0; m_y[s] = 0; m_mag[s] = 0;
         for (int p = 0; p < 256; p++) m_img[s][p] = 0;
      end
      // R1: outputs held while reset is low
      screen_idx = 4'd9;
      border_in  = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         checks++;
         if (pix_src !== 2'd0 || pix_idx !== 4'd0) begin
            errors++;
            $display("FAIL R1 reset: src=%0d idx=%0d expected src=0 idx=0", pix_src, pix_idx);
         end
      end
      border_in = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // R1: no sprite appears before programming
      scan(-2, 20, 0, 3, 0, "R1 hidden after reset");

      // R11/R5: load images of sprites 0, 1, 2 and 15 with upper-bit noise
      foreach (m_img[s]) begin
         if (s == 0 || s == 1 || s == 2 || s == 15) begin
            for (int p = 0; p < 256; p++) begin
               int v, b;
               v = (p * 5 + s * 3 + 1) % 17;
               b = (v == 16) ? 'hF0 : ((v & 15) | ((p & 7) << 4));
               step(-50, -50, 0, 1, 1, (s << 8) | p, b, "R11 R5 image load");
            end
         end
      end

      set_pos(0, 10, 20);
      wr_ctl(0, 4, 'h05);
      scan(5, 30, 18, 38, 0, "R4 R5 single sprite x1");

      set_pos(1, 18, 24);
      wr_ctl(1, 4, 'h0A);
      scan(8, 55, 18, 60, 0, "R3 R7 overlap with zoom x2");

      set_pos(15, -8, -5);
      wr_ctl(15, 4, 'hFD);
      scan(-10, 60, -6, 14, 0, "R6 R7 R8 negative position zoom x4");

      set_pos(2, 0, 0);
      wr_ctl(2, 4, 'h03);
      scan(-2, 20, -2, 20, 0, "R6 X code 00 hides");
      wr_ctl(2, 4, 'h0C);
      scan(-2, 20, -2, 20, 0, "R6 Y code 00 hides");

      scan(8, 40, 18, 45, 1, "R2 border over sprites");

      // R11: moving sprite 0 in the same cycle a covered pixel is mixed
      for (int y = 20; y <= 35; y++) begin
         step(10, y, 0, 6, 1, 'h1000, 10 + (y & 3), "R11 write during mix");
         for (int x = 11; x <= 30; x++)
            step(x, y, 0, (x + y) & 15, 0, 0, 0, "R11 after same-cycle write");
      end

      step(0, 0, 0, 0, 0, 0, 0, "R10 final");
      step(0, 0, 0, 0, 0, 0, 0, "R10 final");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule